// File: doc/BRIEF.md
# Bit-Pattern Step Pulse Generator

This block turns precomputed bit patterns into step pulses for several motion axes at once. For every axis the host supplies two pattern words, one for the plus direction and one for the minus direction. All of these words go in together as one stack entry through a single push strobe. On each time-unit strobe the block takes the next pattern bit of every axis at the same moment. A 1 bit produces a one-clock pulse on that axis's plus or minus output, and a 0 bit produces nothing. This keeps the axes in step for multi-axis interpolation.

Entries are held in a three-level stack: an active word, which is being emitted, and two waiting words. A 2-bit occupancy counter steers each push into the next free level and refuses pushes when all three levels are full. When the active word has been fully emitted, the waiting words move down one level and the counter drops by one. A drop from two entries to one raises a sticky interrupt request, which tells the host to refill the stack before it runs dry. Speed generation is outside this block: the time-unit strobe comes from elsewhere.

Top module: `bitpat_pulse_gen`

## Requirements
- R1: After reset, `stack_level` is 0, `irq`, `drop_flag` and `conflict_flag` are 0, and no pulse output is high.
- R2: Accepted pushes fill the stack levels in order. Stack entries are emitted in the order they were pushed.
- R3: Each push accepted while `stack_level` is below 3 raises `stack_level` by one. A push while `stack_level` is 3 is discarded: the level stays 3, the data is never emitted, and `drop_flag` is set.
- R4: The active word is emitted least-significant bit first, one bit per `tick`. Bit i of an axis word (axis a occupies bits a*WORD_W upward of the pattern ports) appears as a pulse in the clock cycle right after the i-th `tick`. The pulse lasts exactly one clock.
- R5: Plus-direction bits appear only on `pulse_plus` and minus-direction bits appear only on `pulse_minus`, each on its own axis bit.
- R6: After WORD_W ticks the next waiting entry becomes active and `stack_level` decreases by one.
- R7: `irq` is set when `stack_level` goes from 2 to 1. It stays set until `clr_irq` is pulsed.
- R8: While `stack_level` is 0, ticks produce no pulses.
- R9: All axes take their bit on the same `tick`.
- R10: When a plus bit and a minus bit of one axis are both 1, neither pulse is emitted for that axis and `conflict_flag` is set.
- R11: A push in the same cycle as the tick that finishes a word is accepted. The level stays unchanged and the new entry goes behind the ones already waiting.
- R12: A pulse on `clr_err` clears `drop_flag` and `conflict_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-unit strobe, one clock wide |
| push | input | 1 | Push one stack entry |
| push_plus | input | NUM_AXES*WORD_W | Plus-direction words, axis a at bits a*WORD_W upward |
| push_minus | input | NUM_AXES*WORD_W | Minus-direction words, same layout |
| clr_irq | input | 1 | Clear the interrupt request |
| clr_err | input | 1 | Clear the drop and conflict flags |
| pulse_plus | output | NUM_AXES | Plus-direction step pulse per axis |
| pulse_minus | output | NUM_AXES | Minus-direction step pulse per axis |
| stack_level | output | 2 | Number of stack entries held (0 to 3) |
| irq | output | 1 | Sticky low-stack interrupt request |
| drop_flag | output | 1 | Sticky: a push was refused |
| conflict_flag | output | 1 | Sticky: both directions were requested at once |

## Verification
The assertions check the properties that hold on every cycle. No pulse follows a cycle without a tick, and none is emitted while the stack is empty. The two directions never pulse together on one axis. A push into a full stack leaves the level at 3 and sets the drop flag. The interrupt rises on every step from two entries to one and stays set until it is cleared. The bench scenarios cover what needs a sequence of stimulus: the exact bit order of each emitted word, the order in which stacked entries come out, that discarded data never appears, and that a push at a word boundary slots in behind the waiting entries.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int STACK_DEPTH = 3;
  typedef logic [1:0] lvl_t;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_BOTH  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/bpg_stack.sv
module bpg_stack
  import bpg_pkg::*;
#(
  parameter int NUM_AXES = 3,
  parameter int WORD_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [NUM_AXES*WORD_W-1:0] push_plus,
  input  logic [NUM_AXES*WORD_W-1:0] push_minus,
  input  logic                       word_done,
  output logic [NUM_AXES*WORD_W-1:0] head_plus,
  output logic [NUM_AXES*WORD_W-1:0] head_minus,
  output lvl_t                       level,
  output logic                       drop_set,
  output logic                       low_evt
);
  localparam int VW = NUM_AXES * WORD_W;

  logic [VW-1:0] sp_q [STACK_DEPTH];
  logic [VW-1:0] sm_q [STACK_DEPTH];
  logic [VW-1:0] sp_d [STACK_DEPTH];
  logic [VW-1:0] sm_d [STACK_DEPTH];
  lvl_t          lvl_q, lvl_d;
  lvl_t          target;
  logic          accept;
  stk_op_e       op;

  assign accept   = push && (lvl_q != 2'd3);
  assign drop_set = push && (lvl_q == 2'd3);
  assign op       = stk_op_e'({word_done, accept});

  always_comb begin
    for (int s = 0; s < STACK_DEPTH; s++) begin
      sp_d[s] = sp_q[s];
      sm_d[s] = sm_q[s];
    end
    lvl_d  = lvl_q;
    target = lvl_q;
    case (op)
      OP_LOAD:  lvl_d = lvl_q + 2'd1;
      OP_SHIFT: lvl_d = lvl_q - 2'd1;
      OP_BOTH:  target = lvl_q - 2'd1;
      default:  lvl_d = lvl_q;
    endcase
    if (word_done) begin
      for (int s = 0; s < STACK_DEPTH - 1; s++) begin
        sp_d[s] = sp_q[s+1];
        sm_d[s] = sm_q[s+1];
      end
    end
    if (accept) begin
      for (int s = 0; s < STACK_DEPTH; s++) begin
        if (target == lvl_t'(s)) begin
          sp_d[s] = push_plus;
          sm_d[s] = push_minus;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 2'd0;
      for (int s = 0; s < STACK_DEPTH; s++) begin
        sp_q[s] <= '0;
        sm_q[s] <= '0;
      end
    end else begin
      lvl_q <= lvl_d;
      for (int s = 0; s < STACK_DEPTH; s++) begin
        sp_q[s] <= sp_d[s];
        sm_q[s] <= sm_d[s];
      end
    end
  end

  assign head_plus  = sp_q[0];
  assign head_minus = sm_q[0];
  assign level      = lvl_q;
  assign low_evt    = (op == OP_SHIFT) && (lvl_q == 2'd2);
endmodule

// File: rtl/bpg_emit.sv
module bpg_emit #(
  parameter int NUM_AXES = 3,
  parameter int WORD_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       active,
  input  logic [NUM_AXES*WORD_W-1:0] head_plus,
  input  logic [NUM_AXES*WORD_W-1:0] head_minus,
  output logic                       word_done,
  output logic                       conflict_set,
  output logic [NUM_AXES-1:0]        pulse_plus,
  output logic [NUM_AXES-1:0]        pulse_minus
);
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORD_W - 1);

  logic [IW-1:0]       idx_q, idx_d;
  logic                fire;
  logic [NUM_AXES-1:0] pp_d, pm_d, clash;
  logic [NUM_AXES-1:0] pp_q, pm_q;

  assign fire      = tick && active;
  assign word_done = fire && (idx_q == LAST);

  always_comb begin
    idx_d = idx_q;
    if (fire) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    logic [WORD_W-1:0] wp, wm;
    logic              bp, bm;
    assign wp       = head_plus[a*WORD_W +: WORD_W];
    assign wm       = head_minus[a*WORD_W +: WORD_W];
    assign bp       = wp[idx_q];
    assign bm       = wm[idx_q];
    assign clash[a] = fire && bp && bm;
    assign pp_d[a]  = fire && bp && !bm;
    assign pm_d[a]  = fire && bm && !bp;
  end

  assign conflict_set = |clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pp_q  <= '0;
      pm_q  <= '0;
    end else begin
      idx_q <= idx_d;
      pp_q  <= pp_d;
      pm_q  <= pm_d;
    end
  end

  assign pulse_plus  = pp_q;
  assign pulse_minus = pm_q;
endmodule

// File: rtl/bpg_flags.sv
module bpg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic low_evt,
  input  logic drop_set,
  input  logic conflict_set,
  input  logic clr_irq,
  input  logic clr_err,
  output logic irq,
  output logic drop_flag,
  output logic conflict_flag
);
  logic irq_q, irq_d, drop_q, drop_d, cf_q, cf_d;

  always_comb begin
    irq_d  = low_evt  || (irq_q  && !clr_irq);
    drop_d = drop_set || (drop_q && !clr_err);
    cf_d   = conflict_set || (cf_q && !clr_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      drop_q <= 1'b0;
      cf_q   <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      drop_q <= drop_d;
      cf_q   <= cf_d;
    end
  end

  assign irq           = irq_q;
  assign drop_flag     = drop_q;
  assign conflict_flag = cf_q;
endmodule

// File: rtl/bitpat_pulse_gen.sv
module bitpat_pulse_gen #(
  parameter int NUM_AXES = 3,
  parameter int WORD_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       push,
  input  logic [NUM_AXES*WORD_W-1:0] push_plus,
  input  logic [NUM_AXES*WORD_W-1:0] push_minus,
  input  logic                       clr_irq,
  input  logic                       clr_err,
  output logic [NUM_AXES-1:0]        pulse_plus,
  output logic [NUM_AXES-1:0]        pulse_minus,
  output logic [1:0]                 stack_level,
  output logic                       irq,
  output logic                       drop_flag,
  output logic                       conflict_flag
);
  localparam int VW = NUM_AXES * WORD_W;

  logic [1:0]    rst_sync;
  logic          core_rst_n;
  logic [VW-1:0] head_p, head_m;
  logic          word_done, drop_set, low_evt, conflict_set;
  logic [1:0]    level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  bpg_stack #(.NUM_AXES(NUM_AXES), .WORD_W(WORD_W)) u_stack (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .push       (push),
    .push_plus  (push_plus),
    .push_minus (push_minus),
    .word_done  (word_done),
    .head_plus  (head_p),
    .head_minus (head_m),
    .level      (level),
    .drop_set   (drop_set),
    .low_evt    (low_evt)
  );

  bpg_emit #(.NUM_AXES(NUM_AXES), .WORD_W(WORD_W)) u_emit (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .tick         (tick),
    .active       (level != 2'd0),
    .head_plus    (head_p),
    .head_minus   (head_m),
    .word_done    (word_done),
    .conflict_set (conflict_set),
    .pulse_plus   (pulse_plus),
    .pulse_minus  (pulse_minus)
  );

  bpg_flags u_flags (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .low_evt       (low_evt),
    .drop_set      (drop_set),
    .conflict_set  (conflict_set),
    .clr_irq       (clr_irq),
    .clr_err       (clr_err),
    .irq           (irq),
    .drop_flag     (drop_flag),
    .conflict_flag (conflict_flag)
  );

  assign stack_level = level;
endmodule

// File: rtl/bpg_chk.sv
module bpg_chk #(
  parameter int NUM_AXES = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                push,
  input logic                clr_irq,
  input logic [NUM_AXES-1:0] pulse_plus,
  input logic [NUM_AXES-1:0] pulse_minus,
  input logic [1:0]          stack_level,
  input logic                irq,
  input logic                drop_flag
);
  // R4
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((pulse_plus == '0) && (pulse_minus == '0)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_level == 2'd0) |=> ((pulse_plus == '0) && (pulse_minus == '0)));

  // R10
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_plus & pulse_minus) == '0);

  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_level == 2'd3 && push && !tick) |=> (stack_level == 2'd3 && drop_flag));

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_level == 2'd1 && $past(stack_level) == 2'd2) |-> irq);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_irq) |=> irq);

  // R6
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_level == 2'd0) |=> (stack_level <= 2'd1));
endmodule

bind bitpat_pulse_gen bpg_chk #(.NUM_AXES(NUM_AXES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .push        (push),
  .clr_irq     (clr_irq),
  .pulse_plus  (pulse_plus),
  .pulse_minus (pulse_minus),
  .stack_level (stack_level),
  .irq         (irq),
  .drop_flag   (drop_flag)
);

// File: tb/bitpat_pulse_gen_bench.sv
module bitpat_pulse_gen_bench;
  localparam int NA = 3;
  localparam int W  = 16;
  localparam int VW = NA * W;

  logic          clk = 1'b0;
  logic          rst_n, tick, push, clr_irq, clr_err;
  logic [VW-1:0] push_plus, push_minus;
  logic [NA-1:0] pulse_plus, pulse_minus;
  logic [1:0]    stack_level;
  logic          irq, drop_flag, conflict_flag;

  int total = 0;
  int bad   = 0;

  logic [W-1:0] cap_p [NA];
  logic [W-1:0] cap_m [NA];

  always #2.5 clk = ~clk;

  bitpat_pulse_gen #(.NUM_AXES(NA), .WORD_W(W)) u_bitpat_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .push(push),
    .push_plus(push_plus), .push_minus(push_minus),
    .clr_irq(clr_irq), .clr_err(clr_err),
    .pulse_plus(pulse_plus), .pulse_minus(pulse_minus),
    .stack_level(stack_level), .irq(irq),
    .drop_flag(drop_flag), .conflict_flag(conflict_flag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at next negedge
  task automatic step(input logic t, input logic p, input logic [VW-1:0] dp,
                      input logic [VW-1:0] dm);
    tick = t; push = p; push_plus = dp; push_minus = dm;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; push = 1'b0;
  endtask

  task automatic pulse_clr(input logic ci, input logic ce);
    clr_irq = ci; clr_err = ce;
    @(posedge clk);
    @(negedge clk);
    clr_irq = 1'b0; clr_err = 1'b0;
  endtask

  task automatic emit_word(input int ticks, input logic last_push,
                           input logic [VW-1:0] dp, input logic [VW-1:0] dm);
    for (int i = 0; i < ticks; i++) begin
      step(1'b1, last_push && (i == ticks - 1), dp, dm);
      for (int a = 0; a < NA; a++) begin
        cap_p[a][i] = pulse_plus[a];
        cap_m[a][i] = pulse_minus[a];
      end
    end
  endtask

  task automatic cmp_word(input string req, input logic [VW-1:0] ep, input logic [VW-1:0] em);
    for (int a = 0; a < NA; a++) begin
      check(req, {48'd0, cap_p[a]}, {48'd0, ep[a*W +: W]});
      check(req, {48'd0, cap_m[a]}, {48'd0, em[a*W +: W]});
    end
  endtask

  function automatic logic [VW-1:0] mkw(input logic [15:0] s);
    return {s ^ 16'h3C5A, s + 16'h1111, s};
  endfunction

  task automatic t_reset;
    check("R1 level", {62'd0, stack_level}, 64'd0);
    check("R1 flags", {61'd0, irq, drop_flag, conflict_flag}, 64'd0);
    check("R1 pulses", {58'd0, pulse_plus, pulse_minus}, 64'd0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, '0, '0);
      check("R8 idle pulses", {58'd0, pulse_plus, pulse_minus}, 64'd0);
    end
  endtask

  task automatic t_fill_drain;
    logic [VW-1:0] a, b, c, d;
    a = mkw(16'hA5C3); b = mkw(16'h0F96); c = mkw(16'h7E01); d = mkw(16'hFFFF);
    step(1'b0, 1'b1, a, ~a);
    check("R3 level1", {62'd0, stack_level}, 64'd1);
    step(1'b0, 1'b1, b, ~b);
    check("R3 level2", {62'd0, stack_level}, 64'd2);
    step(1'b0, 1'b1, c, ~c);
    check("R3 level3", {62'd0, stack_level}, 64'd3);
    step(1'b0, 1'b1, d, '0);
    check("R3 full stays 3", {62'd0, stack_level}, 64'd3);
    check("R3 drop flag", {63'd0, drop_flag}, 64'd1);
    // one tick then idle cycle: pulse is one clock wide
    step(1'b1, 1'b0, '0, '0);
    check("R4 bit0 plus", {61'd0, pulse_plus}, {61'd0, a[2*W], a[W], a[0]});
    step(1'b0, 1'b0, '0, '0);
    check("R4 one-clock pulse", {58'd0, pulse_plus, pulse_minus}, 64'd0);
    emit_word(W - 1, 1'b0, '0, '0);
    for (int x = 0; x < NA; x++) begin
      check("R4 R5 R9 first word plus", {49'd0, cap_p[x][W-2:0]}, {49'd0, a[x*W+1 +: W-1]});
      check("R5 first word minus", {49'd0, cap_m[x][W-2:0]}, {49'd0, ~a[x*W+1 +: W-1]});
    end
    check("R6 level after word", {62'd0, stack_level}, 64'd2);
    check("R7 irq not yet", {63'd0, irq}, 64'd0);
    emit_word(W, 1'b0, '0, '0);
    cmp_word("R2 second entry", b, ~b);
    check("R6 level 1", {62'd0, stack_level}, 64'd1);
    check("R7 irq on 2to1", {63'd0, irq}, 64'd1);
    step(1'b0, 1'b0, '0, '0);
    check("R7 irq sticky", {63'd0, irq}, 64'd1);
    pulse_clr(1'b1, 1'b0);
    check("R7 irq cleared", {63'd0, irq}, 64'd0);
    emit_word(W, 1'b0, '0, '0);
    cmp_word("R2 R3 third entry, dropped data absent", c, ~c);
    check("R6 level 0", {62'd0, stack_level}, 64'd0);
    check("R7 no irq on 1to0", {63'd0, irq}, 64'd0);
    emit_word(W, 1'b0, '0, '0);
    cmp_word("R8 empty stack", '0, '0);
  endtask

  task automatic t_conflict;
    logic [VW-1:0] p, m;
    p = {16'h1234, 16'h8001, 16'h00FF};
    m = {16'h4321, 16'h7FFE, 16'h0FF0};
    pulse_clr(1'b0, 1'b1);
    check("R12 drop cleared", {63'd0, drop_flag}, 64'd0);
    step(1'b0, 1'b1, p, m);
    emit_word(W, 1'b0, '0, '0);
    cmp_word("R10 overlap masked", p & ~m, m & ~p);
    check("R10 conflict flag", {63'd0, conflict_flag}, 64'd1);
    pulse_clr(1'b0, 1'b1);
    check("R12 conflict cleared", {63'd0, conflict_flag}, 64'd0);
  endtask

  task automatic t_boundary_push;
    logic [VW-1:0] a, b;
    a = mkw(16'h5AA5); b = mkw(16'hC00C);
    step(1'b0, 1'b1, a, '0);
    emit_word(W, 1'b1, b, ~b);
    cmp_word("R11 current word", a, '0);
    check("R11 level held", {62'd0, stack_level}, 64'd1);
    check("R11 no drop", {63'd0, drop_flag}, 64'd0);
    emit_word(W, 1'b0, '0, '0);
    cmp_word("R11 pushed entry follows", b, ~b);
    check("R11 empty after", {62'd0, stack_level}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; push = 1'b0; clr_irq = 1'b0; clr_err = 1'b0;
    push_plus = '0; push_minus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_fill_drain();
    t_conflict();
    t_boundary_push();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule